// File: doc/BRIEF.md
# Cell-Delineation-Loss Soak Timer for Automatic Path RDI

This block watches the receive-side loss-of-cell-delineation condition and measures how long it has lasted. Time is counted in frames: each strobe of `frame_tick` marks one 125 µs frame, and the condition level is sampled only on those strobes. Once the condition has lasted longer than a host-programmed soak value, the block raises a request to insert path RDI into the outgoing G1 byte. The request is passed on only while the automatic-RDI enable input is high.

The soak value sits in a single host register, and the host can both write it and read it back. After reset the register holds 32 frames, which is a 4 ms soak. Any value the host writes is lost on reset. The RDI request stays up for as long as the condition is seen on each strobe. It falls at the first strobe that finds the condition gone. The transmit overhead builder ORs the 8-bit `g1_rdi` mask into its G1 byte.

Top module: `loca_rdi_soak`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `host_rdata` reads 32 and both `rdi_req` and `g1_rdi` are zero.
- R2: A cycle with `host_wr` high loads `host_wdata` into the soak register, and `host_rdata` shows the new value from the next cycle on. In a cycle without `host_wr` the register keeps its value.
- R3: A reset that comes after a host write puts the soak register back to 32.
- R4: Let the soak value be S and let the enable be high. `rdi_req` rises one clock after the (S+1)-th consecutive frame strobe that samples the condition present, and not earlier.
- R5: With a soak value of 0, `rdi_req` rises one clock after the first strobe that samples the condition present.
- R6: A frame strobe that samples the condition absent clears the persistence count, and `rdi_req` is low from the next clock. A later soak starts again from zero.
- R7: Between frame strobes, changes on `loca_in` have no effect on `rdi_req` or on the persistence count.
- R8: While `rdi_auto_en` is low, `rdi_req` is low, but the persistence count keeps running. If the enable is raised after the soak has already expired, `rdi_req` goes high in that same cycle.
- R9: `g1_rdi` is 8'h08 when `rdi_req` is high and 8'h00 when it is low. Bit [3] of the byte is G1 bit 5.
- R10: Once raised, `rdi_req` stays high through every later strobe that samples the condition present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe at each 125 µs frame |
| loca_in | input | 1 | Loss-of-cell-delineation condition level |
| rdi_auto_en | input | 1 | Enable for automatic RDI insertion |
| host_wr | input | 1 | Host write strobe for the soak register |
| host_wdata | input | SOAK_W | Soak value to write, in frames |
| host_rdata | output | SOAK_W | Current soak register value |
| rdi_req | output | 1 | Request to insert path RDI |
| g1_rdi | output | 8 | G1 OR-mask: bit [3] carries the RDI |

## Verification
The soak register and the persistence state are each one register stage away from their inputs. A host write or a frame strobe therefore shows at the ports one clock after the edge that samples it. The enable is the exception: it acts on `rdi_req` and `g1_rdi` in the same cycle. The bench drives every input on the falling edge and holds a strobe for exactly one rising edge. It then samples on the next falling edge, which falls after the one register update and before the next. The enable checks sample in the same half-cycle in which the enable is changed.

// File: rtl/loca_soak_pkg.sv
package loca_soak_pkg;
  localparam int unsigned DEF_SOAK_W     = 8;
  localparam int unsigned DEF_SOAK_RESET = 32;
  // G1 bit 5 (bit 1 is the MSB) is bit [3] of the byte
  localparam int unsigned G1_RDI_POS     = 3;

  typedef enum logic [1:0] {
    SOAK_IDLE   = 2'd0,
    SOAK_RUN    = 2'd1,
    SOAK_EXPIRE = 2'd2
  } soak_phase_e;
endpackage

// File: rtl/loca_soak_reg.sv
module loca_soak_reg #(
  parameter int unsigned SOAK_W     = 8,
  parameter int unsigned SOAK_RESET = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SOAK_W-1:0] wr_data,
  output logic [SOAK_W-1:0] soak_q
);
  localparam logic [SOAK_W-1:0] RST_VAL = SOAK_W'(SOAK_RESET);

  logic [SOAK_W-1:0] soak_d;

  always_comb begin
    soak_d = soak_q;
    if (wr_en) soak_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soak_q <= RST_VAL;
    else        soak_q <= soak_d;
  end
endmodule

// File: rtl/loca_soak_cnt.sv
module loca_soak_cnt
  import loca_soak_pkg::*;
#(
  parameter int unsigned SOAK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cond,
  input  logic [SOAK_W-1:0] soak_lim,
  output logic              expired
);
  soak_phase_e       phase_q, phase_d;
  logic [SOAK_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  // The count saturates at the limit, so it cannot wrap.
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (tick) begin
      if (!cond) begin
        phase_d = SOAK_IDLE;
        cnt_d   = '0;
      end else if (phase_q == SOAK_EXPIRE) begin
        phase_d = SOAK_EXPIRE;
      end else if (cnt_q >= soak_lim) begin
        phase_d = SOAK_EXPIRE;
      end else begin
        phase_d = SOAK_RUN;
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_en = tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SOAK_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign expired = (phase_q == SOAK_EXPIRE);
endmodule

// File: rtl/loca_rdi_gate.sv
module loca_rdi_gate
  import loca_soak_pkg::*;
#(
  parameter int unsigned RDI_POS = G1_RDI_POS
) (
  input  logic       expired,
  input  logic       enable,
  output logic       req,
  output logic [7:0] g1_mask
);
  always_comb begin
    req     = expired & enable;
    g1_mask = '0;
    g1_mask[RDI_POS] = req;
  end
endmodule

// File: rtl/loca_rdi_soak.sv
module loca_rdi_soak
  import loca_soak_pkg::*;
#(
  parameter int unsigned SOAK_W     = DEF_SOAK_W,
  parameter int unsigned SOAK_RESET = DEF_SOAK_RESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              loca_in,
  input  logic              rdi_auto_en,
  input  logic              host_wr,
  input  logic [SOAK_W-1:0] host_wdata,
  output logic [SOAK_W-1:0] host_rdata,
  output logic              rdi_req,
  output logic [7:0]        g1_rdi
);
  logic [SOAK_W-1:0] soak_val;
  logic              soak_done;

  loca_soak_reg #(.SOAK_W(SOAK_W), .SOAK_RESET(SOAK_RESET)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr),
    .wr_data (host_wdata),
    .soak_q  (soak_val)
  );

  loca_soak_cnt #(.SOAK_W(SOAK_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frame_tick),
    .cond     (loca_in),
    .soak_lim (soak_val),
    .expired  (soak_done)
  );

  loca_rdi_gate #(.RDI_POS(G1_RDI_POS)) u_gate (
    .expired (soak_done),
    .enable  (rdi_auto_en),
    .req     (rdi_req),
    .g1_mask (g1_rdi)
  );

  assign host_rdata = soak_val;
endmodule

// File: rtl/loca_rdi_soak_chk.sv
module loca_rdi_soak_chk #(
  parameter int unsigned SOAK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              loca_in,
  input logic              rdi_auto_en,
  input logic              host_wr,
  input logic [SOAK_W-1:0] host_wdata,
  input logic [SOAK_W-1:0] host_rdata,
  input logic              rdi_req,
  input logic [7:0]        g1_rdi
);
  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> host_rdata == $past(host_wdata));

  assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(host_rdata));

  assert_zero_soak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && loca_in && !host_wr && host_rdata == '0) |=> (rdi_req || !rdi_auto_en));

  assert_clear_on_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !loca_in) |=> !rdi_req);

  assert_quiet_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdi_auto_en && $past(rdi_auto_en) && !$past(frame_tick)) |-> rdi_req == $past(rdi_req));

  assert_hold_while_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdi_req && rdi_auto_en && frame_tick && loca_in) |=> (rdi_req || !rdi_auto_en));

  assert_mask_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(g1_rdi) <= 1);
endmodule

bind loca_rdi_soak loca_rdi_soak_chk #(.SOAK_W(SOAK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_tick  (frame_tick),
  .loca_in     (loca_in),
  .rdi_auto_en (rdi_auto_en),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .rdi_req     (rdi_req),
  .g1_rdi      (g1_rdi)
);

// File: tb/loca_rdi_soak_tb.sv
module loca_rdi_soak_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_tick = 1'b0;
  logic         loca_in = 1'b0;
  logic         rdi_auto_en = 1'b0;
  logic         host_wr = 1'b0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] host_rdata;
  logic         rdi_req;
  logic [7:0]   g1_rdi;

  int n_chk = 0;
  int n_bad = 0;
  int run   = 0;
  int soak  = 32;

  always #2.5 clk = ~clk;

  loca_rdi_soak u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .loca_in(loca_in),
    .rdi_auto_en(rdi_auto_en), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rdi_req(rdi_req), .g1_rdi(g1_rdi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    int exp_r;
    exp_r = (rdi_auto_en && run > soak) ? 1 : 0;
    check(req, int'(rdi_req), exp_r);
    check({req, "/R9"}, int'(g1_rdi), exp_r ? 8 : 0);
  endtask

  task automatic strobe(input logic l);
    @(negedge clk);
    frame_tick = 1'b1;
    loca_in = l;
    @(negedge clk);
    frame_tick = 1'b0;
    if (l) run++; else run = 0;
  endtask

  task automatic host_write(input int v);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = W'(v);
    @(negedge clk);
    host_wr = 1'b0;
    soak = v;
    check("R2 write", int'(host_rdata), v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 rdata in reset", int'(host_rdata), 32);
    check("R1 req in reset", int'(rdi_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run = 0;
    soak = 32;
    @(negedge clk);
    check("R1 rdata", int'(host_rdata), 32);
    check("R1 req", int'(rdi_req), 0);
    check("R1 g1", int'(g1_rdi), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", int'(host_rdata), 32);
    check("R1 req", int'(rdi_req), 0);
    rdi_auto_en = 1'b1;

    // R4/R10: default soak of 32 frames
    for (int i = 0; i < 36; i++) begin
      strobe(1'b1);
      check_out("R4 default");
    end
    strobe(1'b0);
    check_out("R6 drop");

    // R4/R5/R6/R10: sweep soak values 0..12
    for (int s = 0; s <= 12; s++) begin
      host_write(s);
      for (int i = 0; i < s + 3; i++) begin
        strobe(1'b1);
        check_out(s == 0 ? "R5 zero soak" : "R4 sweep");
      end
      strobe(1'b0);
      check_out("R6 drop");
    end

    // R6: an absent strobe mid-soak restarts the count
    host_write(5);
    for (int i = 0; i < 4; i++) strobe(1'b1);
    strobe(1'b0);
    check_out("R6 restart");
    for (int i = 0; i < 7; i++) begin
      strobe(1'b1);
      check_out("R6 after restart");
    end

    // R7: loca_in toggles without strobes leave the output alone
    @(negedge clk);
    loca_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 no tick", int'(rdi_req), 1);
    strobe(1'b0);
    host_write(3);
    strobe(1'b1);
    @(negedge clk);
    loca_in = 1'b0;
    repeat (3) @(negedge clk);
    loca_in = 1'b1;
    @(negedge clk);
    check_out("R7 partial");
    for (int i = 0; i < 4; i++) begin
      strobe(1'b1);
      check_out("R7 continue");
    end
    strobe(1'b0);

    // R8: enable low masks the request, the count keeps running
    @(negedge clk);
    rdi_auto_en = 1'b0;
    host_write(2);
    for (int i = 0; i < 5; i++) begin
      strobe(1'b1);
      check_out("R8 disabled");
    end
    rdi_auto_en = 1'b1;
    #1;
    check("R8 same-cycle enable", int'(rdi_req), 1);
    check("R8 g1 mask R9", int'(g1_rdi), 8);
    @(negedge clk);
    rdi_auto_en = 1'b0;
    #1;
    check("R8 same-cycle disable", int'(rdi_req), 0);
    rdi_auto_en = 1'b1;
    strobe(1'b0);

    // R4 upper bound: soak 255
    host_write(255);
    for (int i = 0; i < 258; i++) begin
      strobe(1'b1);
      check_out("R4 max soak");
    end
    strobe(1'b0);

    // R3: reset restores the default after a write
    host_write(9);
    do_reset();
    check("R3 restored", int'(host_rdata), 32);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule